// File: doc/BRIEF.md
# Pipelined Reciprocal Square Root Unit

This unit computes 1/sqrt(x) for an unsigned fixed-point sample. It accepts one sample per clock and returns one result per clock after a fixed delay of 17 cycles. A valid flag travels with each sample, so a consumer only has to watch the output flag. The result is meaningful only in cycles where that flag is high.

Each sample is first shifted left by an even bit count, which puts the mantissa in [0.25, 1). A straight-line seed then gives a first estimate of 1/sqrt of that mantissa. The seed has one coefficient pair for the half-range [0.25, 0.5) and another for [0.5, 1). Two Newton–Raphson steps, each computing y·(3 − m·y²)/2, refine the estimate. Finally the value is scaled back by half the shift count, rounded to nearest and saturated into the output format. There is a register after every multiply. A valid shift register of the same depth runs beside the data.

Top module: `rsqrt_pipe`

## Requirements
- R1: A sample presented with `in_valid` high at a clock edge produces `out_valid` high exactly 17 edges later. `out_valid` is low in every cycle that has no such sample behind it.
- R2: A new sample may be presented on every clock. Back-to-back samples give back-to-back results in the same order, with no gaps.
- R3: `rst` is synchronous and active high. While it is sampled high, `out_valid` and `out_data` read 0 after the edge. Samples in flight, or samples presented while `rst` is high, never raise `out_valid`. After reset is released, `out_valid` stays low until the pipeline has refilled.
- R4: `in_data` is unsigned Q8.8 (16 bits, 8 of them fractional), and `out_data` is unsigned Q8.8. For a nonzero input code x, the output code lies within 9/16 LSB of 4096/sqrt(x). This means round-to-nearest, with an absolute error no larger than 2^-8.
- R5: An input code of 0 gives the largest output code, 16'hFFFF, with `out_valid` high as for any other sample.
- R6: When the true result is a whole number of output LSBs, the output is exact. The input codes 1, 4, 16, 64, 256, 1024, 4096 and 16384 give 4096, 2048, 1024, 512, 256, 128, 64 and 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_data` as a sample to process this cycle |
| in_data | input | 16 | Operand, unsigned Q8.8 |
| out_valid | output | 1 | Marks `out_data` as a result this cycle |
| out_data | output | 16 | 1/sqrt of the operand, unsigned Q8.8, saturated |

## Verification
The bench sweeps every one of the 65536 input codes back to back. It compares each result against a real-valued 1/sqrt. This catches a wrong seed coefficient or a wrong shift parity, both of which leave residual errors of several LSBs. It also catches truncation in place of rounding, which pushes errors past half an LSB. Zero and the exact powers of four are aimed at the saturation path and at off-by-one rounding offsets. A wrong zero path returns a large but unsaturated code, and a misplaced rounding bit moves exact results by one code. Sparse valid patterns and a reset in mid-stream check the valid line. A line that is one stage too short or too long shifts every flag by a cycle, and a line that is not cleared lets stale results out after reset.

// File: rtl/rsqrt_pipe.sv
module rsqrt_pipe #(
  parameter int IN_W     = 16,
  parameter int IN_FRAC  = 8,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 8,
  parameter int FRAC     = 20,
  parameter int ITERS    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  localparam int YW      = FRAC + 2;
  localparam int QW      = FRAC + 4;
  localparam int NSW     = $clog2(IN_W);
  localparam int HW      = NSW - 1;
  localparam int SB      = 1 + HW + IN_W;
  localparam int LAT     = 9 + 4 * ITERS;
  localparam int SH_BASE = FRAC - OUT_FRAC + (IN_W - IN_FRAC) / 2;
  localparam int SHW     = $clog2(SH_BASE + 1);
  localparam int CW      = $clog2(LAT + 2);
  localparam int RW      = $clog2(LAT + 1);
  localparam int CA_HI   = $rtoi(1.80168 * (2.0 ** FRAC) + 0.5);
  localparam int CB_HI   = $rtoi(0.82843 * (2.0 ** FRAC) + 0.5);
  localparam int CA_LO   = $rtoi(2.54794 * (2.0 ** FRAC) + 0.5);
  localparam int CB_LO   = $rtoi(2.34315 * (2.0 ** FRAC) + 0.5);
  localparam logic [QW-1:0]    THREE = QW'(3) << FRAC;
  localparam logic [QW-1:0]    P_LO  = QW'(7) << (FRAC - 3);
  localparam logic [QW-1:0]    P_HI  = QW'(9) << (FRAC - 3);
  localparam logic [OUT_W-1:0] MAXC  = '1;

  // valid line, one bit per data stage
  logic [LAT-1:0] vsr;
  always_ff @(posedge clk)
    if (rst) vsr <= '0;
    else     vsr <= {vsr[LAT-2:0], in_valid};
  assign out_valid = vsr[LAT-1];

  // capture and leading-one search
  logic [IN_W-1:0] x1, x2;
  logic [NSW-1:0]  msb_c, nsh_c, nsh2;
  logic            z2;

  always_comb begin
    msb_c = '0;
    for (int k = 0; k < IN_W; k++)
      if (x1[k]) msb_c = NSW'(k);
  end
  assign nsh_c = (NSW'(IN_W - 1) - msb_c) & ~NSW'(1);

  always_ff @(posedge clk)
    if (rst) begin
      x1 <= '0; x2 <= '0; nsh2 <= '0; z2 <= 1'b0;
    end else begin
      x1   <= in_data;
      x2   <= x1;
      nsh2 <= nsh_c;
      z2   <= (x1 == '0);
    end

  // even normalising shift
  logic [IN_W-1:0] m3;
  logic [HW-1:0]   h3;
  logic            z3;
  always_ff @(posedge clk)
    if (rst) begin
      m3 <= '0; h3 <= '0; z3 <= 1'b0;
    end else begin
      m3 <= z2 ? {1'b1, {(IN_W-1){1'b0}}} : (x2 << nsh2);
      h3 <= nsh2[NSW-1:1];
      z3 <= z2;
    end

  // linear seed, coefficients picked by the half-range of m
  logic [YW-1:0]      cb_c, bm4, y5;
  logic [YW+IN_W-1:0] bm_w;
  logic               seg4;
  logic [SB-1:0]      s4, s5;

  assign cb_c = m3[IN_W-1] ? YW'(CB_HI) : YW'(CB_LO);
  assign bm_w = cb_c * m3;

  always_ff @(posedge clk)
    if (rst) begin
      bm4 <= '0; seg4 <= 1'b0; s4 <= '0; y5 <= '0; s5 <= '0;
    end else begin
      bm4  <= YW'(bm_w >> IN_W);
      seg4 <= m3[IN_W-1];
      s4   <= {z3, h3, m3};
      y5   <= (seg4 ? YW'(CA_HI) : YW'(CA_LO)) - bm4;
      s5   <= s4;
    end

  // Newton refinement
  logic [ITERS:0][YW-1:0] it_y;
  logic [ITERS:0][SB-1:0] it_s;
  assign it_y[0] = y5;
  assign it_s[0] = s5;

  for (genvar g = 0; g < ITERS; g++) begin : g_newton
    logic [YW-1:0]      ya, yb, yc, yd;
    logic [SB-1:0]      sa, sbr, sc, sd;
    logic [QW-1:0]      yy, pp, rr;
    logic [2*YW-1:0]    sq_w;
    logic [IN_W+QW-1:0] pm_w;
    logic [YW+QW-1:0]   yr_w;

    assign sq_w = it_y[g] * it_y[g];
    assign pm_w = sa[IN_W-1:0] * yy;
    assign yr_w = yc * rr;

    always_ff @(posedge clk)
      if (rst) begin
        ya <= '0; yb <= '0; yc <= '0; yd <= '0;
        sa <= '0; sbr <= '0; sc <= '0; sd <= '0;
        yy <= '0; pp <= '0; rr <= '0;
      end else begin
        ya  <= it_y[g];
        sa  <= it_s[g];
        yy  <= QW'(sq_w >> FRAC);
        yb  <= ya;
        sbr <= sa;
        pp  <= QW'(pm_w >> IN_W);
        yc  <= yb;
        sc  <= sbr;
        rr  <= THREE - pp;
        yd  <= YW'(yr_w >> (FRAC + 1));
        sd  <= sc;
      end

    assign it_y[g+1] = yd;
    assign it_s[g+1] = sd;

    AST_NEWTON_RESIDUAL: assert property (@(posedge clk) disable iff (rst)
      vsr[6+4*g] |-> (pp >= P_LO && pp <= P_HI))
      else $error("m*y^2 left its band in step %0d", g); // R4
  end

  // denormalise, round, saturate
  logic [YW-1:0]  yf;
  logic [SB-1:0]  sf;
  logic [HW-1:0]  hf, h14;
  logic           zf, z14, z15, z16;
  logic [SHW-1:0] shv14_c, shv15_c;
  logic [YW:0]    rnd14, q15;
  logic [OUT_W-1:0] sat16;

  assign yf      = it_y[ITERS];
  assign sf      = it_s[ITERS];
  assign hf      = sf[IN_W +: HW];
  assign zf      = sf[SB-1];
  assign shv14_c = SHW'(SH_BASE) - SHW'(hf);
  assign shv15_c = SHW'(SH_BASE) - SHW'(h14);

  always_ff @(posedge clk)
    if (rst) begin
      rnd14 <= '0; h14 <= '0; z14 <= 1'b0;
      q15 <= '0; z15 <= 1'b0;
      sat16 <= '0; z16 <= 1'b0;
      out_data <= '0;
    end else begin
      rnd14    <= {1'b0, yf} + ((YW+1)'(1) << (shv14_c - 1'b1));
      h14      <= hf;
      z14      <= zf;
      q15      <= rnd14 >> shv15_c;
      z15      <= z14;
      sat16    <= (z15 || q15 > (YW+1)'(MAXC)) ? MAXC : OUT_W'(q15);
      z16      <= z15;
      out_data <= sat16;
    end

  // assertion bookkeeping
  logic [CW-1:0] inflight;
  logic [RW-1:0] since_rst;
  always_ff @(posedge clk)
    if (rst) begin
      inflight  <= '0;
      since_rst <= '0;
    end else begin
      inflight <= inflight + CW'(in_valid) - CW'(out_valid);
      if (since_rst != RW'(LAT)) since_rst <= since_rst + 1'b1;
    end

  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (since_rst < RW'(LAT)) |-> !out_valid) else $error("early out_valid"); // R3
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LAT)) else $error("too many samples in flight"); // R2
  AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight != '0) else $error("result without a sample"); // R1
  AST_NORM_RANGE: assert property (@(posedge clk) disable iff (rst)
    vsr[2] |-> m3[IN_W-1 -: 2] != 2'b00) else $error("mantissa below 0.25"); // R4
  AST_NORM_HELD: assert property (@(posedge clk) disable iff (rst)
    vsr[4+4*ITERS] |-> sf[IN_W-1 -: 2] != 2'b00) else $error("mantissa lost"); // R4
  AST_NONZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data != '0) else $error("zero result"); // R4
  AST_ZERO_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (vsr[LAT-2] && z16) |=> out_data == MAXC) else $error("zero not saturated"); // R5

endmodule

// File: tb/rsqrt_pipe_tb_top.sv
module rsqrt_pipe_tb_top;
  localparam int LAT = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  initial forever #4 clk = ~clk;

  rsqrt_pipe dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    edge_seen = 1'b0;
  bit    rst_seen = 1'b1;
  string vtag = "R3";
  bit    qv[$];
  int    qd[$];

  // reference: what the inputs were LAT edges ago
  always @(posedge clk) begin
    edge_seen <= 1'b1;
    rst_seen  <= rst;
    if (rst) begin
      qv.delete();
      qd.delete();
    end else begin
      qv.push_back(in_valid);
      qd.push_back(int'(in_data));
      if (qv.size() > LAT) begin
        void'(qv.pop_front());
        void'(qd.pop_front());
      end
    end
  end

  task automatic check_value(int x);
    real ideal, diff;
    int  ie;
    n_chk++;
    if (x == 0) begin
      if (out_data !== 16'hFFFF) begin
        n_fail++;
        $display("FAIL R5 x=0 actual=%0d expected=65535", out_data);
      end
    end else begin
      ideal = 4096.0 / $sqrt(real'(x));
      ie    = $rtoi(ideal + 0.5);
      diff  = real'(out_data) - ideal;
      if (diff < 0.0) diff = -diff;
      if (ideal == real'(ie)) begin
        if (int'(out_data) != ie) begin
          n_fail++;
          $display("FAIL R6 x=%0d actual=%0d expected=%0d", x, out_data, ie);
        end
      end else if (diff > 0.5625) begin
        n_fail++;
        $display("FAIL R4 x=%0d actual=%0d expected=%f", x, out_data, ideal);
      end
    end
  endtask

  always @(negedge clk) begin : chk_blk
    bit ev;
    if (edge_seen && !done) begin
      if (rst_seen) begin
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 16'h0) begin
          n_fail++;
          $display("FAIL R3 reset state actual=%0b/%0d expected=0/0", out_valid, out_data);
        end
      end else begin
        ev = (qv.size() == LAT) ? qv[0] : 1'b0;
        n_chk++;
        if (out_valid !== ev) begin
          n_fail++;
          $display("FAIL %s out_valid actual=%0b expected=%0b", vtag, out_valid, ev);
        end
        if (ev && out_valid === 1'b1) check_value(qd[0]);
      end
    end
  end

  task automatic drive(bit v, int d);
    @(negedge clk);
    in_valid = v;
    in_data  = 16'(d);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=expired expected=finished");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin : stim
    int exact_in[12] = '{1, 4, 16, 64, 256, 1024, 4096, 16384, 0, 65535, 0, 2};
    logic [31:0] lcg = 32'h1234_5678;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3: pipeline refills with nothing inside, no output
    repeat (20) drive(0, 0);

    // R1: lone sample
    vtag = "R1";
    drive(1, 256);
    repeat (20) drive(0, 0);

    // R5, R6: zero and exact cases back to back
    vtag = "R2";
    foreach (exact_in[i]) drive(1, exact_in[i]);
    repeat (20) drive(0, 0);

    // R2, R4: full sweep at one sample per clock
    for (int d = 0; d < 65536; d++) drive(1, d);
    repeat (20) drive(0, 0);

    // R1: sparse valid pattern
    vtag = "R1";
    for (int i = 0; i < 300; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      drive((i % 3) == 0, int'(lcg[23:8]));
    end
    repeat (20) drive(0, 0);

    // R3: reset with samples in flight and offered during reset
    for (int i = 0; i < 10; i++) drive(1, 100 + i * 37);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_data = 16'd500;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    vtag = "R3";
    repeat (25) drive(0, 0);

    vtag = "R1";
    for (int i = 0; i < 5; i++) drive(1, 7 + i * 1000);
    repeat (22) drive(0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule